// File: doc/BRIEF.md
# Per-Block Lock and Erase-Status Manager

This block keeps, for every erase block of a two-bank flash controller, a lock bit and an erase-incomplete bit. A request names an operation, a bank and a block index. The block compares it with the stored lock state and the write-protect input. It then either grants the request or denies it. A grant starts the operation engine. A deny raises a one-cycle lock-violation flag towards the status register, and the engine is not started.

While a granted operation is running, the block ignores new requests. It waits for the engine's completion report and then updates its bits. A successful lock-set marks the block locked. A successful clear-locks unlocks the whole bank. An erase leaves the erase-incomplete bit set if it fails and clears it if it succeeds. An internal reset that arrives during an erase sets the erase-incomplete bit of every block that erase was touching.

Both kinds of bit survive the internal reset. Only the power-on input zeroes them. A read port returns a status byte for any block, together with a flag that says whether the byte may be trusted at that moment.

Top module: `blk_lock_mgr`

## Requirements
- R1: While `por_n` is low at a clock edge, every lock bit and every erase-incomplete bit is zeroed, and `grant`, `deny` and the busy state are cleared.
- R2: A low `rst_n` at a clock edge leaves all lock bits unchanged and clears the busy state, `grant` and `deny`.
- R3: Operation codes on `req_op`: 1 set lock, 2 clear all locks of a bank, 3 block erase, 4 word write, 5 bank erase. Codes 0, 6 and 7 get no response. Set lock is permitted only when `wp_n` is 1, and it sets the lock bit of the addressed block when it completes with `done_ok` = 1.
- R4: Clear locks is permitted only when `wp_n` is 1. On successful completion it clears every lock bit of the addressed bank and leaves the other bank unchanged.
- R5: A block erase or word write is permitted when the addressed block is unlocked, or when `wp_n` is 1. Otherwise it is denied.
- R6: A bank erase is permitted when `wp_n` is 1 or when the addressed bank has no lock bit set. Otherwise it is denied.
- R7: In the cycle after a valid request is accepted, exactly one of `grant` or `deny` is high for one cycle. A denied request changes no stored bit.
- R8: While an operation is in progress, requests produce neither `grant` nor `deny`, and they change no stored bit.
- R9: When a block erase completes, the block's erase-incomplete bit becomes the inverse of `done_ok`. A bank erase does the same for every block of the bank. A word write changes no stored bit when it completes. A failed set lock or clear locks changes no stored bit. Any completion report ends the busy state.
- R10: If `rst_n` goes low while a block erase or bank erase is in progress, the erase-incomplete bit of the affected block, or of every block of the affected bank, is set.
- R11: `rd_status` for (`rd_bank`, `rd_blk`) has bit 0 = lock (1 locked), bit 1 = erase incomplete (1 failed), and bits 7 to 2 = 0. `rd_valid` is 1 only when no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on initialisation, active low, synchronous; zeroes all bits |
| rst_n | input | 1 | Internal reset, active low, synchronous; keeps stored bits |
| wp_n | input | 1 | Write protect, 0 = protection asserted |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R3) |
| req_bank | input | BANK_W | Bank of the request |
| req_blk | input | IDX_W | Block index of the request |
| grant | output | 1 | One-cycle pulse: operation started |
| deny | output | 1 | One-cycle pulse: lock violation |
| done_valid | input | 1 | Completion report from the operation engine |
| done_ok | input | 1 | Completion succeeded |
| rd_bank | input | BANK_W | Bank for the status read |
| rd_blk | input | IDX_W | Block for the status read |
| rd_status | output | 8 | Block status byte |
| rd_valid | output | 1 | Status byte may be used (idle) |

## Verification
The bench builds the block with four blocks per bank and two banks, so the index is 2 bits wide. With this size, every block of both banks can be read back after each phase. The bench sweeps block erase and word write over every bank, every block, both write-protect levels and both lock states, with completions that alternately pass and fail. Directed sequences then cover the lock set and clear under both protect levels, bank erase with and without locks, requests made while busy, and the internal reset arriving in the middle of an erase.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_SET_LOCK   = 3'd1,
        OP_CLR_LOCKS  = 3'd2,
        OP_BLK_ERASE  = 3'd3,
        OP_WORD_WRITE = 3'd4,
        OP_BANK_ERASE = 3'd5
    } lkm_op_e;
endpackage

// File: rtl/lkm_permit.sv
module lkm_permit
    import lkm_pkg::*;
(
    input  logic [2:0] op,
    input  logic       wp_n,
    input  logic       blk_locked,
    input  logic       bank_any_locked,
    output logic       is_cmd,
    output logic       permit
);
    always_comb begin
        is_cmd = 1'b1;
        permit = 1'b0;
        case (op)
            OP_SET_LOCK,
            OP_CLR_LOCKS:  permit = wp_n;
            OP_BLK_ERASE,
            OP_WORD_WRITE: permit = wp_n | ~blk_locked;
            OP_BANK_ERASE: permit = wp_n | ~bank_any_locked;
            default:       is_cmd = 1'b0;
        endcase
    end
endmodule

// File: rtl/lkm_status_fmt.sv
module lkm_status_fmt (
    input  logic       locked,
    input  logic       ers_fail,
    input  logic       busy,
    output logic [7:0] status,
    output logic       valid
);
    always_comb begin
        status = {6'b0, ers_fail, locked};
        valid  = ~busy;
    end
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
    import lkm_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    parameter int NUM_BANKS  = 2,
    localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [IDX_W-1:0]  req_blk,
    output logic              grant,
    output logic              deny,
    input  logic              done_valid,
    input  logic              done_ok,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [IDX_W-1:0]  rd_blk,
    output logic [7:0]        rd_status,
    output logic              rd_valid
);
    typedef struct packed {
        logic [NUM_BANKS-1:0][NUM_BLOCKS-1:0] lock;
        logic [NUM_BANKS-1:0][NUM_BLOCKS-1:0] ers;
        logic                                 busy;
        lkm_op_e                              op;
        logic [BANK_W-1:0]                    bank;
        logic [IDX_W-1:0]                     blk;
        logic                                 grant;
        logic                                 deny;
    } state_t;

    localparam state_t ST_POR = '0;

    state_t st_d, st_q;
    logic   is_cmd, permit;
    logic   busy_w;

    lkm_permit u_permit (
        .op              (req_op),
        .wp_n            (wp_n),
        .blk_locked      (st_q.lock[req_bank][req_blk]),
        .bank_any_locked (|st_q.lock[req_bank]),
        .is_cmd          (is_cmd),
        .permit          (permit)
    );

    lkm_status_fmt u_fmt (
        .locked   (st_q.lock[rd_bank][rd_blk]),
        .ers_fail (st_q.ers[rd_bank][rd_blk]),
        .busy     (st_q.busy),
        .status   (rd_status),
        .valid    (rd_valid)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;
        if (!rst_n) begin
            if (st_q.busy) begin
                case (st_q.op)
                    OP_BLK_ERASE:  st_d.ers[st_q.bank][st_q.blk] = 1'b1;
                    OP_BANK_ERASE: st_d.ers[st_q.bank] = {NUM_BLOCKS{1'b1}};
                    default: ;
                endcase
            end
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (done_valid) begin
                case (st_q.op)
                    OP_SET_LOCK:   if (done_ok) st_d.lock[st_q.bank][st_q.blk] = 1'b1;
                    OP_CLR_LOCKS:  if (done_ok) st_d.lock[st_q.bank] = '0;
                    OP_BLK_ERASE:  st_d.ers[st_q.bank][st_q.blk] = ~done_ok;
                    OP_BANK_ERASE: st_d.ers[st_q.bank] = {NUM_BLOCKS{~done_ok}};
                    default: ;
                endcase
                st_d.busy = 1'b0;
            end
        end else if (req_valid && is_cmd) begin
            if (permit) begin
                st_d.grant = 1'b1;
                st_d.busy  = 1'b1;
                st_d.op    = lkm_op_e'(req_op);
                st_d.bank  = req_bank;
                st_d.blk   = req_blk;
            end else begin
                st_d.deny  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= ST_POR;
        else        st_q <= st_d;
    end

    assign grant  = st_q.grant;
    assign deny   = st_q.deny;
    assign busy_w = st_q.busy;
endmodule

// File: rtl/lkm_checker.sv
module lkm_checker (
    input logic clk,
    input logic por_n,
    input logic rst_n,
    input logic wp_n,
    input logic req_valid,
    input logic grant,
    input logic deny,
    input logic busy,
    input logic done_valid
);
    assert_one_response_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(grant && deny));

    assert_response_needs_req_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (grant || deny) |-> $past(req_valid));

    assert_deny_only_protected_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        deny |-> !$past(wp_n));

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $past(busy) |-> (!grant && !deny));

    assert_done_releases_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $past(busy && done_valid) |-> !busy);
endmodule

bind blk_lock_mgr lkm_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .req_valid  (req_valid),
    .grant      (grant),
    .deny       (deny),
    .busy       (busy_w),
    .done_valid (done_valid)
);

// File: tb/sim_blk_lock_mgr.sv
`timescale 1ns/1ps
module sim_blk_lock_mgr;
    localparam int NB = 4;
    logic clk = 0;
    logic por_n = 0, rst_n = 1, wp_n = 1, req_valid = 0;
    logic [2:0] req_op = 0;
    logic       req_bank = 0;
    logic [1:0] req_blk = 0;
    logic grant, deny, done_valid = 0, done_ok = 0;
    logic       rd_bank = 0;
    logic [1:0] rd_blk = 0;
    logic [7:0] rd_status;
    logic       rd_valid;

    int tests = 0, fails = 0;
    bit mlock [2][NB];
    bit mers  [2][NB];

    always #4 clk = ~clk;

    blk_lock_mgr #(.NUM_BLOCKS(NB), .NUM_BANKS(2)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
        .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_blk(req_blk),
        .grant(grant), .deny(deny), .done_valid(done_valid), .done_ok(done_ok),
        .rd_bank(rd_bank), .rd_blk(rd_blk), .rd_status(rd_status), .rd_valid(rd_valid));

    task automatic chk(bit cond, string req, int act, int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_all(string req);
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < NB; k++) begin
                int e;
                rd_bank = 1'(b); rd_blk = 2'(k);
                #1;
                e = {mers[b][k], mlock[b][k]} | 256;
                chk({rd_valid, rd_status} == 9'(e), req, {rd_valid, rd_status}, e);
            end
    endtask

    function automatic bit any_lock(int b);
        bit r = 0;
        for (int k = 0; k < NB; k++) r |= mlock[b][k];
        return r;
    endfunction

    function automatic bit exp_permit(int op, int b, int k, bit wp);
        case (op)
            1, 2:    return wp;
            3, 4:    return wp | !mlock[b][k];
            default: return wp | !any_lock(b);
        endcase
    endfunction

    task automatic issue(int op, int b, int k, bit wp);
        @(negedge clk);
        req_valid = 1; req_op = 3'(op); req_bank = 1'(b); req_blk = 2'(k); wp_n = wp;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_op(int op, int b, int k, bit wp, bit ok, string req);
        bit p;
        p = exp_permit(op, b, k, wp);
        issue(op, b, k, wp);
        chk(grant == p && deny == !p, req, {grant, deny}, {p, !p});
        if (p) begin
            chk(rd_valid == 0, "R11 busy", rd_valid, 0);
            done_valid = 1; done_ok = ok;
            @(negedge clk);
            done_valid = 0;
            if (ok && op == 1) mlock[b][k] = 1;
            if (ok && op == 2) for (int j = 0; j < NB; j++) mlock[b][j] = 0;
            if (op == 3) mers[b][k] = !ok;
            if (op == 5) for (int j = 0; j < NB; j++) mers[b][j] = !ok;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        chk(grant == 0 && deny == 0, "R1 outputs", {grant, deny}, 0);
        read_all("R1 por state");

        for (int b = 0; b < 2; b++)
            for (int k = 0; k < NB; k++) do_op(1, b, k, 0, 1, "R3 set lock protected");
        read_all("R3 no change");
        do_op(1, 0, 1, 1, 1, "R3 set lock");
        do_op(1, 1, 2, 1, 1, "R3 set lock");
        do_op(1, 0, 3, 1, 1, "R3 set lock");
        do_op(1, 1, 0, 1, 0, "R3 set lock failed");
        read_all("R3 locks");

        for (int op = 3; op <= 4; op++)
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NB; k++)
                    for (int w = 0; w < 2; w++)
                        do_op(op, b, k, w[0], ((b + k + w) % 2) == 0, "R5 R9 sweep");
        read_all("R9 erase flags");

        do_op(5, 0, 0, 0, 1, "R6 bank erase protected");
        do_op(5, 1, 0, 0, 1, "R6 bank erase protected");
        read_all("R7 deny no change");
        do_op(5, 1, 0, 1, 0, "R6 bank erase");
        read_all("R9 bank erase fail");

        issue(6, 0, 0, 1);
        chk(grant == 0 && deny == 0, "R3 bad code", {grant, deny}, 0);

        issue(3, 0, 2, 0);
        chk(grant == 1, "R5 grant", grant, 1);
        issue(1, 1, 3, 1);
        chk(grant == 0 && deny == 0, "R8 busy", {grant, deny}, 0);
        issue(2, 0, 0, 1);
        chk(grant == 0 && deny == 0, "R8 busy", {grant, deny}, 0);
        done_valid = 1; done_ok = 1;
        @(negedge clk);
        done_valid = 0; mers[0][2] = 0;
        read_all("R8 no change");

        issue(3, 0, 0, 1);
        chk(grant == 1, "R10 grant", grant, 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        mers[0][0] = 1;
        read_all("R10 R2 abort");
        issue(5, 0, 0, 1);
        chk(grant == 1, "R10 grant bank", grant, 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int j = 0; j < NB; j++) mers[0][j] = 1;
        read_all("R10 bank abort");

        do_op(2, 0, 0, 0, 1, "R4 clear protected");
        do_op(2, 0, 0, 1, 1, "R4 clear");
        read_all("R4 bank only");
        do_op(5, 1, 0, 0, 1, "R6 bank erase locked");
        do_op(5, 0, 0, 0, 1, "R6 bank erase unlocked");
        read_all("R9 bank erase ok");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule